// File: doc/BRIEF.md
# Sleep Wake-Source Detector

This block runs while a device sleeps and decides whether it should wake. It watches two sources. The first is a sampled comparator bit from the line receiver that carries a wake tone near 625 kHz. The second is a local wake pin that is accepted only after a minimum pulse duration. When either source qualifies, the block raises an inhibit output that enables the external supplies. It also records which source caused the wake.

Both inputs pass through synchronizers. The tone path counts comparator rising edges in a sliding window of 64 cycles, which is 6.4 µs at the intended 10 MHz clock. A window holding 3 to 5 edges counts as in band. The tone is accepted after 320 consecutive in-band cycles. The pin path uses a duration counter that clears whenever the pin drops. Once the pulse has passed the qualifying length, the counter keeps running to a fixed firing point 40 µs after the edge. All counts are parameters expressed in clock cycles, with 1 µs equal to 10 cycles.

The inhibit output and the cause bits stay latched until reset or until the sleep flag rises again. Detection is active only while the sleep flag is high.

Top module: `wake_detect_top`

## Requirements
- R1: After reset, inh_o is 0 and cause_o is 2'b00.
- R2: While sleep_i is low, neither tone activity nor pin activity raises inh_o.
- R3: A continuous tone whose rising-edge period is 16 cycles (625 kHz) or 20 cycles (500 kHz) raises inh_o no earlier than 300 and no later than 450 cycles after the tone starts. cause_o then reads 2'b01, where bit 0 is the tone cause.
- R4: A pin pulse shorter than 280 cycles never wakes the block. This is checked at 150 and 260 cycles.
- R5: A pin pulse of at least 280 cycles wakes the block even if the pin is released before inh_o rises. cause_o then reads 2'b10, where bit 1 is the pin cause.
- R6: A qualifying pin pulse raises inh_o no earlier than 390 and no later than 450 cycles after its rising edge.
- R7: Once inh_o is high, inh_o and cause_o hold their values while sleep_i is held or dropped. Later source activity does not change them.
- R8: On the cycle after sleep_i rises, inh_o and cause_o read 0.
- R9: A tone that gives fewer than 3 or more than 5 rising edges per 64-cycle window never wakes the block. This is checked at edge periods of 8 and 32 cycles.
- R10: If the window falls out of band, the tone accumulation restarts. A tone that resumes after a gap of more than 64 cycles must not raise inh_o within 300 cycles of resuming.
- R11: If both sources qualify in the same cycle, cause_o reads 2'b11. If the pin qualifies one cycle after the tone, cause_o reads 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock (10 MHz intended) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Sleep flag; a rising edge is a new sleep request |
| tone_cmp_i | input | 1 | Sampled line comparator bit |
| wake_pin_i | input | 1 | Local wake pin, active high |
| inh_o | output | 1 | Inhibit output that enables the supplies, latched |
| cause_o | output | 2 | Latched wake cause: bit 1 is the pin, bit 0 is the tone |

## Verification
The tone acceptance and the pin firing point can land on the same clock edge, and the cause register must then record both sources. The bench first measures, at the ports, the latency from tone start to wake and from pin edge to wake. It then offsets the two stimuli by the difference between those latencies so that both detectors complete together, and expects cause 2'b11. A second run shifts the pin by one cycle and expects the tone cause alone, with no later change in the cause.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef struct packed {
    logic pin;
    logic tone;
  } wake_cause_t;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic ff_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= 1'b0;
        else         ff_q <= d_i;
      end
      assign q_o = ff_q;
    end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
      assign q_o = ff_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wake_tone_qual.sv
module wake_tone_qual #(
  parameter int unsigned WIN_CYC  = 64,
  parameter int unsigned EDGE_MIN = 3,
  parameter int unsigned EDGE_MAX = 5,
  parameter int unsigned HOLD_CYC = 320
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cmp_i,
  output logic hit_o
);
  localparam int unsigned EW = wake_pkg::cnt_w(WIN_CYC);
  localparam int unsigned HW = wake_pkg::cnt_w(HOLD_CYC);

  logic               cmp_q;
  logic [WIN_CYC-1:0] hist_q;
  logic [EW-1:0]      edge_cnt_q;
  logic [HW-1:0]      hold_q;
  logic               rise, oldest, in_band;

  assign rise    = cmp_i & ~cmp_q;
  assign oldest  = hist_q[WIN_CYC-1];
  assign in_band = (edge_cnt_q >= EW'(EDGE_MIN)) && (edge_cnt_q <= EW'(EDGE_MAX));

  // sliding window: running edge count updated from entering and leaving bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q      <= 1'b0;
      hist_q     <= '0;
      edge_cnt_q <= '0;
    end else if (!en_i) begin
      cmp_q      <= 1'b0;
      hist_q     <= '0;
      edge_cnt_q <= '0;
    end else begin
      cmp_q  <= cmp_i;
      hist_q <= {hist_q[WIN_CYC-2:0], rise};
      case ({rise, oldest})
        2'b10:   edge_cnt_q <= edge_cnt_q + 1'b1;
        2'b01:   edge_cnt_q <= edge_cnt_q - 1'b1;
        default: edge_cnt_q <= edge_cnt_q;
      endcase
    end
  end

  // consecutive in-band cycles; any out-of-band cycle restarts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hold_q <= '0;
    else if (!en_i || !in_band)    hold_q <= '0;
    else if (hold_q != HW'(HOLD_CYC)) hold_q <= hold_q + 1'b1;
  end

  assign hit_o = (hold_q == HW'(HOLD_CYC));
endmodule

// File: rtl/wake_pin_filter.sv
module wake_pin_filter #(
  parameter int unsigned QUAL_CYC = 280,
  parameter int unsigned FIRE_CYC = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pin_i,
  output logic hit_o
);
  localparam int unsigned CW = wake_pkg::cnt_w(FIRE_CYC);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  // before arming: counts high cycles, clears on drop; after: free-runs to fire point
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (armed_q) begin
      if (cnt_q != CW'(FIRE_CYC)) cnt_q <= cnt_q + 1'b1;
    end else if (pin_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(QUAL_CYC - 1)) armed_q <= 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign hit_o = armed_q && (cnt_q == CW'(FIRE_CYC));
endmodule

// File: rtl/wake_detect_top.sv
module wake_detect_top #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned WIN_CYC       = 64,
  parameter int unsigned EDGE_MIN      = 3,
  parameter int unsigned EDGE_MAX      = 5,
  parameter int unsigned TONE_HOLD_CYC = 320,
  parameter int unsigned PIN_QUAL_CYC  = 280,
  parameter int unsigned PIN_FIRE_CYC  = 400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       tone_cmp_i,
  input  logic       wake_pin_i,
  output logic       inh_o,
  output logic [1:0] cause_o
);
  import wake_pkg::*;

  logic        cmp_s, pin_s;
  logic        sleep_q, sleep_rise;
  logic        det_en, tone_hit, pin_hit;
  logic        inh_q;
  wake_cause_t cause_q;

  wake_sync #(.STAGES(SYNC_STAGES)) u_sync_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tone_cmp_i), .q_o(cmp_s)
  );
  wake_sync #(.STAGES(SYNC_STAGES)) u_sync_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wake_pin_i), .q_o(pin_s)
  );

  assign sleep_rise = sleep_i & ~sleep_q;
  assign det_en     = sleep_i & ~inh_q;

  wake_tone_qual #(
    .WIN_CYC(WIN_CYC), .EDGE_MIN(EDGE_MIN), .EDGE_MAX(EDGE_MAX), .HOLD_CYC(TONE_HOLD_CYC)
  ) u_tone (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(det_en), .cmp_i(cmp_s), .hit_o(tone_hit)
  );

  wake_pin_filter #(
    .QUAL_CYC(PIN_QUAL_CYC), .FIRE_CYC(PIN_FIRE_CYC)
  ) u_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(det_en), .pin_i(pin_s), .hit_o(pin_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q <= 1'b0;
      inh_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      sleep_q <= sleep_i;
      if (sleep_rise) begin
        inh_q   <= 1'b0;
        cause_q <= '0;
      end else if (det_en && (tone_hit || pin_hit)) begin
        inh_q        <= 1'b1;
        cause_q.tone <= tone_hit;
        cause_q.pin  <= pin_hit;
      end
    end
  end

  assign inh_o   = inh_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/wake_detect_chk.sv
module wake_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_i,
  input logic       tone_cmp_i,
  input logic       wake_pin_i,
  input logic       inh_o,
  input logic [1:0] cause_o
);
  // R7: an asserted inhibit always carries a cause, and a cause implies inhibit
  p_cause_with_inh_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_o == (cause_o != 2'b00));

  // R7: latched until a new sleep request
  p_inh_latched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_o && !$rose(sleep_i)) |=> inh_o);

  p_cause_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_o && !$rose(sleep_i)) |=> $stable(cause_o));

  // R8: sleep request clears
  p_clear_on_sleep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_i) |=> (!inh_o && cause_o == 2'b00));

  // R2: no wake while awake
  p_no_wake_awake_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |=> !$rose(inh_o));
endmodule

bind wake_detect_top wake_detect_chk u_chk (.*);

// File: tb/wake_detect_top_tb.sv
module wake_detect_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep = 1'b0;
  logic       cmp = 1'b0;
  logic       pin = 1'b0;
  logic       inh;
  logic [1:0] cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // tone generator control
  bit tone_on = 1'b0;
  int half    = 8;
  int ph      = 0;

  typedef struct {
    string      req;
    logic       inh;
    logic [1:0] cause;
    bit         use_cause;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  wake_detect_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .tone_cmp_i(cmp),
    .wake_pin_i(pin), .inh_o(inh), .cause_o(cause)
  );

  // tone waveform updated mid-cycle, away from both edges
  always @(posedge clk) begin
    #3;
    if (!tone_on) begin
      cmp = 1'b0;
      ph  = 0;
    end else begin
      cmp = ((ph % (2 * half)) < half);
      ph  = ph + 1;
    end
  end

  // monitor: pops expected items and compares with ports
  always @(negedge clk) begin
    item_t it;
    #2;
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      checks++;
      if (inh !== it.inh || (it.use_cause && cause !== it.cause)) begin
        errors++;
        $display("FAIL %s: inh=%0b cause=%b expected inh=%0b cause=%b",
                 it.req, inh, cause, it.inh, it.cause);
      end
    end
  end

  task automatic expect_now(input string req, input logic e_inh,
                            input logic [1:0] e_cause, input bit use_c);
    item_t it;
    it.req = req; it.inh = e_inh; it.cause = e_cause; it.use_cause = use_c;
    sb_q.push_back(it);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_inh(input int max, output int n);
    n = 0;
    while (!inh && n < max) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic go_sleep();
    @(negedge clk);
    tone_on = 1'b0; pin = 1'b0; sleep = 1'b0;
    cycles(4);
    sleep = 1'b1;
    @(negedge clk);
    expect_now("R8", 1'b0, 2'b00, 1'b1);
    cycles(4);
  endtask

  int n, lt, lp, dt, dp;

  initial begin
    cycles(3);
    expect_now("R1", 1'b0, 2'b00, 1'b1);
    rst_n = 1'b1;
    cycles(2);

    // R2: sources active while awake
    tone_on = 1'b1; pin = 1'b1;
    cycles(600);
    expect_now("R2", 1'b0, 2'b00, 1'b1);
    tone_on = 1'b0; pin = 1'b0;

    // R4: short pin pulses rejected
    go_sleep();
    pin = 1'b1; cycles(150); pin = 1'b0;
    cycles(500);
    expect_now("R4", 1'b0, 2'b00, 1'b1);
    pin = 1'b1; cycles(260); pin = 1'b0;
    cycles(500);
    expect_now("R4", 1'b0, 2'b00, 1'b1);

    // R6: long pin pulse, timing window; calibrate pin latency
    go_sleep();
    pin = 1'b1;
    cycles(389);
    expect_now("R6", 1'b0, 2'b00, 1'b1);
    wait_inh(61, n);
    expect_now("R6", 1'b1, 2'b10, 1'b1);
    lp = 389 + n;
    cycles(40); pin = 1'b0;
    // R7: stays latched through pin release and sleep drop
    cycles(100);
    expect_now("R7", 1'b1, 2'b10, 1'b1);
    sleep = 1'b0;
    cycles(50);
    expect_now("R7", 1'b1, 2'b10, 1'b1);

    // R5: pulse released before firing point still wakes
    go_sleep();
    pin = 1'b1; cycles(300); pin = 1'b0;
    wait_inh(200, n);
    expect_now("R5", 1'b1, 2'b10, 1'b1);

    // R3: 625 kHz tone; calibrate tone latency
    go_sleep();
    half = 8; tone_on = 1'b1;
    cycles(299);
    expect_now("R3", 1'b0, 2'b00, 1'b1);
    wait_inh(151, n);
    expect_now("R3", 1'b1, 2'b01, 1'b1);
    lt = 299 + n;
    // R7: further pin activity does not alter cause
    pin = 1'b1; cycles(450); pin = 1'b0;
    expect_now("R7", 1'b1, 2'b01, 1'b1);

    // R3: 500 kHz tone accepted
    go_sleep();
    half = 10; tone_on = 1'b1;
    cycles(299);
    expect_now("R3", 1'b0, 2'b00, 1'b1);
    wait_inh(151, n);
    expect_now("R3", 1'b1, 2'b01, 1'b1);

    // R9: too fast and too slow
    go_sleep();
    half = 4; tone_on = 1'b1;
    cycles(800);
    expect_now("R9", 1'b0, 2'b00, 1'b1);
    tone_on = 1'b0; cycles(2);
    half = 16; tone_on = 1'b1;
    cycles(800);
    expect_now("R9", 1'b0, 2'b00, 1'b1);

    // R10: gap restarts accumulation
    go_sleep();
    half = 8; tone_on = 1'b1;
    cycles(250);
    tone_on = 1'b0;
    cycles(80);
    tone_on = 1'b1;
    cycles(300);
    expect_now("R10", 1'b0, 2'b00, 1'b1);
    wait_inh(200, n);
    expect_now("R10", 1'b1, 2'b01, 1'b1);

    // R11: both sources complete together
    dt = (lp > lt) ? lp - lt : 0;
    dp = (lt > lp) ? lt - lp : 0;
    go_sleep();
    half = 8;
    fork
      begin cycles(dt); tone_on = 1'b1; end
      begin cycles(dp); pin = 1'b1; end
    join
    wait_inh(700, n);
    expect_now("R11", 1'b1, 2'b11, 1'b1);

    // R11: pin one cycle late -> tone only, and it stays so (R7)
    go_sleep();
    fork
      begin cycles(dt); tone_on = 1'b1; end
      begin cycles(dp + 1); pin = 1'b1; end
    join
    wait_inh(700, n);
    expect_now("R11", 1'b1, 2'b01, 1'b1);
    cycles(20);
    expect_now("R7", 1'b1, 2'b01, 1'b1);
    tone_on = 1'b0; pin = 1'b0;

    cycles(3);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule